// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock of an SPI master from its faster module clock. A packed clock-control word picks one of two division schemes. The linear scheme divides by any even ratio, 2*(N+1). The power-of-two scheme divides by 2^M, which reaches much lower rates with only a few bits. Software tries the linear field first and falls back to the exponent field only when the ratio it needs does not fit in the linear field.

The transfer engine drives an enable. While the enable is low the serial clock rests at the clock-polarity level, and the block takes in the divider setting and the polarity. While the enable is high the block toggles the serial clock with a 50% duty cycle. Together with each change of the serial clock it raises a one-cycle strobe: a leading strobe when the clock leaves its idle level and a trailing strobe when it returns. The shift logic uses these strobes to launch and capture data. The setting in force cannot change during a transfer, so a transfer never sees a short pulse.

Top module: `spi_clk_div`

## Requirements
- R1: When bit 12 of the control word is 1 (linear mode), each half period of the serial clock lasts N+1 module clock cycles, where N is the control field in bits 7:0.
- R2: When bit 12 is 0 (power-of-two mode) and M, the field in bits 11:8, is at least 1, each half period lasts 2^(M-1) module clock cycles. The full period is therefore 2^M cycles.
- R3: In power-of-two mode M=0 gives a half period of one cycle, the same as divide-by-2.
- R4: While en_i is low, sclk_o equals the cpol_i value sampled at the previous rising edge, and lead_o and trail_o stay low.
- R5: The first change of sclk_o after en_i rises follows the H-th rising edge at which en_i is sampled high, where H is the half period. That change is flagged by lead_o.
- R6: The divider setting and the polarity are taken at the last rising edge at which en_i is low. Changes to clk_ctl_i while en_i is high have no effect on the serial clock until en_i has returned low.
- R7: While enabled, every half period has the same length, so the duty cycle is 50%.
- R8: Each strobe lasts one cycle and appears in the same cycle as the sclk_o change it marks. lead_o and trail_o never appear together, and while enabled sclk_o never changes without one of them. lead_o marks the change away from the polarity level and trail_o marks the change back to it.
- R9: After reset, sclk_o, lead_o and trail_o are 0.
- R10: The extreme settings hold exactly: N=255 gives a half period of 256 cycles and M=15 gives a half period of 16384 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_ctl_i | input | 13 | Control word: bits 7:0 linear field, bits 11:8 exponent field, bit 12 scheme select |
| en_i | input | 1 | Run request from the transfer engine |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe with each change away from the idle level |
| trail_o | output | 1 | One-cycle strobe with each change back to the idle level |

## Verification
The setting capture and the start of clock generation can fall in the same cycle. This happens when the control word changes on the very edge at which the enable is first seen high. In about half of the random runs, and in a directed case, the bench replaces clk_ctl_i at the moment it raises en_i. It then checks that every half period still matches the setting present one cycle earlier. During each run the bench keeps writing random control words and checks that the half periods do not change. After each run it flips the polarity while idle and checks that the idle level follows one cycle later with no strobe.

// File: rtl/spi_clk_div_pkg.sv
`timescale 1ns/1ps
package spi_clk_div_pkg;
  localparam int unsigned DEF_LIN_W = 8;
  localparam int unsigned DEF_EXP_W = 4;

  typedef enum logic {
    SEL_POW2 = 1'b0,
    SEL_LIN  = 1'b1
  } rate_sel_e;
endpackage

// File: rtl/spi_clk_div_decode.sv
`timescale 1ns/1ps
module spi_clk_div_decode import spi_clk_div_pkg::*; #(
  parameter int unsigned LIN_W  = DEF_LIN_W,
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned HALF_W = 14,
  localparam int unsigned CTL_W = LIN_W + EXP_W + 1
) (
  input  logic [CTL_W-1:0]  ctl_i,
  output logic [HALF_W-1:0] half_m1_o
);
  logic [LIN_W-1:0]  lin_fld;
  logic [EXP_W-1:0]  exp_fld;
  rate_sel_e         sel;
  logic [HALF_W-1:0] pow_m1;

  assign lin_fld = ctl_i[LIN_W-1:0];
  assign exp_fld = ctl_i[LIN_W+EXP_W-1:LIN_W];
  assign sel     = rate_sel_e'(ctl_i[CTL_W-1]);

  // half-1 for 2^(M-1): ones in the bits below M-1; M=0 and M=1 both give 0
  for (genvar g = 0; g < HALF_W; g++) begin : g_pow
    assign pow_m1[g] = ((g + 1) < int'(exp_fld));
  end

  always_comb begin
    if (sel == SEL_LIN) half_m1_o = HALF_W'(lin_fld);
    else                half_m1_o = pow_m1;
  end
endmodule

// File: rtl/spi_clk_div_hold.sv
`timescale 1ns/1ps
module spi_clk_div_hold #(
  parameter int unsigned HALF_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [HALF_W-1:0] half_m1_i,
  input  logic              cpol_i,
  output logic [HALF_W-1:0] half_m1_o,
  output logic              cpol_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_m1_o <= '0;
      cpol_o    <= 1'b0;
    end else if (!en_i) begin
      half_m1_o <= half_m1_i;
      cpol_o    <= cpol_i;
    end
  end
endmodule

// File: rtl/spi_clk_div_gen.sv
`timescale 1ns/1ps
module spi_clk_div_gen #(
  parameter int unsigned HALF_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              cpol_hold_i,
  input  logic [HALF_W-1:0] half_m1_i,
  output logic              sclk_o,
  output logic              lead_o,
  output logic              trail_o
);
  logic [HALF_W-1:0] cnt_q;
  logic              term;

  assign term = (cnt_q == half_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sclk_o  <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      sclk_o  <= cpol_i;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else begin
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
      if (term) begin
        cnt_q  <= '0;
        sclk_o <= ~sclk_o;
        if (sclk_o == cpol_hold_i) lead_o  <= 1'b1;
        else                       trail_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_clk_div.sv
`timescale 1ns/1ps
module spi_clk_div import spi_clk_div_pkg::*; #(
  parameter int unsigned LIN_W = DEF_LIN_W,
  parameter int unsigned EXP_W = DEF_EXP_W,
  localparam int unsigned CTL_W  = LIN_W + EXP_W + 1,
  localparam int unsigned POW_W  = (1 << EXP_W) - 2,
  localparam int unsigned HALF_W = (LIN_W > POW_W) ? LIN_W : POW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTL_W-1:0] clk_ctl_i,
  input  logic             en_i,
  input  logic             cpol_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [HALF_W-1:0] dec_half_m1;
  logic [HALF_W-1:0] act_half_m1;
  logic              act_cpol;

  spi_clk_div_decode #(
    .LIN_W (LIN_W),
    .EXP_W (EXP_W),
    .HALF_W(HALF_W)
  ) i_decode (
    .ctl_i    (clk_ctl_i),
    .half_m1_o(dec_half_m1)
  );

  spi_clk_div_hold #(
    .HALF_W(HALF_W)
  ) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .half_m1_i(dec_half_m1),
    .cpol_i   (cpol_i),
    .half_m1_o(act_half_m1),
    .cpol_o   (act_cpol)
  );

  spi_clk_div_gen #(
    .HALF_W(HALF_W)
  ) i_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .cpol_i     (cpol_i),
    .cpol_hold_i(act_cpol),
    .half_m1_i  (act_half_m1),
    .sclk_o     (sclk_o),
    .lead_o     (lead_o),
    .trail_o    (trail_o)
  );
endmodule

// File: rtl/spi_clk_div_chk.sv
`timescale 1ns/1ps
module spi_clk_div_chk #(
  parameter int unsigned RUN_W = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic cpol_i,
  input logic sclk_o,
  input logic lead_o,
  input logic trail_o
);
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] last_q;
  logic             armed_q;
  logic             have_q;
  logic             strobe;

  assign strobe = lead_o | trail_o;

  // length of each phase, measured between strobes of one enabled run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      last_q  <= '0;
      armed_q <= 1'b0;
      have_q  <= 1'b0;
    end else if (!en_i) begin
      run_q   <= '0;
      armed_q <= 1'b0;
      have_q  <= 1'b0;
    end else if (strobe) begin
      if (armed_q) begin
        last_q <= run_q;
        have_q <= 1'b1;
      end
      run_q   <= 1;
      armed_q <= 1'b1;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));

  assert_strobe_on_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |-> (sclk_o != $past(sclk_o)));

  assert_edge_has_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (sclk_o != $past(sclk_o))) |-> strobe);

  assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !strobe);

  assert_idle_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sclk_o == $past(cpol_i)));

  assert_even_duty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && strobe && armed_q && have_q) |-> (run_q == last_q));
endmodule

bind spi_clk_div spi_clk_div_chk #(.RUN_W(16)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .cpol_i (cpol_i),
  .sclk_o (sclk_o),
  .lead_o (lead_o),
  .trail_o(trail_o)
);

// File: tb/test_spi_clk_div.sv
`timescale 1ns/1ps
module test_spi_clk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] clk_ctl = '0;
  logic        en = 1'b0;
  logic        cpol = 1'b0;
  logic        sclk, lead, trail;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  spi_clk_div i_spi_clk_div (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .clk_ctl_i(clk_ctl),
    .en_i     (en),
    .cpol_i   (cpol),
    .sclk_o   (sclk),
    .lead_o   (lead),
    .trail_o  (trail)
  );

  function automatic int exp_half(input logic [12:0] c);
    if (c[12]) return int'(c[7:0]) + 1;
    if (c[11:8] == 4'd0) return 1;
    return 1 << (int'(c[11:8]) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // One enabled run: expects nedges strobes, each H cycles apart
  task automatic run_case(input logic [12:0] ctl, input bit pol, input int nedges,
                          input string req, input bit swap_at_start);
    int  h;
    int  gap;
    int  edges;
    bit  lvl;
    h = exp_half(ctl);
    clk_ctl = ctl;
    cpol = pol;
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk(sclk == pol, "R4 idle level", sclk, pol);
    en = 1'b1;
    if (swap_at_start) clk_ctl = 13'($urandom);
    gap = 0;
    edges = 0;
    lvl = pol;
    while (edges < nedges) begin
      @(negedge clk);
      gap++;
      if (edges > 0) clk_ctl = 13'($urandom);
      if (lead || trail) begin
        chk(gap == h, (edges == 0) ? "R5 first edge" : req, gap, h);
        chk(lead == (lvl == pol), "R8 strobe kind", lead, lvl == pol);
        chk(!(lead && trail), "R8 exclusive", trail, 0);
        chk(sclk == !lvl, "R8 edge with strobe", sclk, !lvl);
        lvl = !lvl;
        gap = 0;
        edges++;
      end else begin
        if (sclk != lvl) chk(1'b0, "R8 edge without strobe", sclk, lvl);
        if (gap > h) begin
          chk(1'b0, "R7 half period overrun", gap, h);
          break;
        end
      end
    end
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!lead && !trail, "R4 no strobe idle", lead | trail, 0);
    chk(sclk == pol, "R4 back to idle", sclk, pol);
    cpol = !pol;
    @(negedge clk);
    chk(sclk == !pol, "R4 idle follows cpol", sclk, !pol);
    chk(!lead && !trail, "R4 quiet on cpol change", lead | trail, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    #12;
    chk(sclk == 0 && lead == 0 && trail == 0, "R9 reset", {sclk, lead, trail}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 0 && lead == 0 && trail == 0, "R9 after reset", {sclk, lead, trail}, 0);

    run_case({1'b1, 4'd0, 8'd0},   1'b0, 6, "R1 linear N=0", 1'b0);
    run_case({1'b1, 4'd9, 8'd5},   1'b1, 6, "R1 linear N=5", 1'b0);
    run_case({1'b1, 4'd0, 8'd255}, 1'b0, 4, "R10 linear N=255", 1'b0);
    run_case({1'b0, 4'd0, 8'd77},  1'b1, 6, "R3 pow M=0", 1'b0);
    run_case({1'b0, 4'd1, 8'd0},   1'b0, 6, "R2 pow M=1", 1'b0);
    run_case({1'b0, 4'd4, 8'd3},   1'b1, 6, "R2 pow M=4", 1'b1);
    run_case({1'b1, 4'd2, 8'd3},   1'b0, 6, "R6 ctl swap at enable", 1'b1);
    run_case({1'b0, 4'd15, 8'd0},  1'b0, 2, "R10 pow M=15", 1'b0);

    for (int i = 0; i < 30; i++) begin
      logic [12:0] c;
      c = 13'($urandom);
      if (c[12]) c[7:6] = 2'b00;
      else       c[11:8] = 4'($urandom_range(0, 9));
      run_case(c, 1'($urandom), 6, c[12] ? "R7 random linear" : "R7 random pow", 1'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #950000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R5 act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule